// File: doc/BRIEF.md
# Pulse-Density BCD Conversion Counter

This block is the digital half of a charge-balancing pulse-modulation A/D converter. On every rising edge of the sample clock it registers a one-bit comparator decision. The registered bit leaves the block as the modulator output, which steers the external reference switch. The same bit gates the clock into a decimal event counter. The analog loop drives the duty cycle of that bit toward the ratio of input voltage to reference, so the number of gated clocks in a fixed window is proportional to the input.

A free-running sequencer splits every conversion cycle into a counting window of `FULL_SCALE * PRESCALE` clocks and a tail of `TAIL_CLKS` clocks. A prescaler divides the gated clocks by `PRESCALE`, so a bit that is high through the whole window gives exactly `FULL_SCALE` counts. On the first clock of the tail, the BCD count moves to the result register and a one-clock strobe is issued. A completion flag then stays high for `HOLD_CLKS` clocks. A count that would pass `FULL_SCALE - 1` sets an overflow flag, and the result then reads `E` in every digit.

Top module: `pdm_bcd_converter`

## Requirements
- R1: `mod_out` equals the value `comp_in` had at the previous rising clock edge. It is 0 after reset.
- R2: Let the clock edges of a cycle be numbered 0 to `CYCLE-1`, where edge 0 is the first edge after reset is released and `CYCLE = FULL_SCALE*PRESCALE + TAIL_CLKS`. Let K be the number of edges 0 to `FULL_SCALE*PRESCALE-1` at which `mod_out` is 1. The transferred count is floor(K / `PRESCALE`). It is coded as four BCD digits, with digit 0 (least significant) in bits [3:0] and digit 3 in bits [15:12].
- R3: If that count exceeds `FULL_SCALE - 1`, `overflow` is 1 after the transfer and `result_bcd` is 16'hEEEE. Otherwise `overflow` is 0.
- R4: `xfer_strobe` is high for exactly one clock per cycle, directly after edge `FULL_SCALE*PRESCALE`, and is low at all other times.
- R5: `conv_done` is high for exactly `HOLD_CLKS` clocks, starting in the same clock as `xfer_strobe`. It is low for the rest of the cycle.
- R6: `result_bcd` and `overflow` change only at a transfer. Between transfers they hold their values.
- R7: The count restarts from zero at edge 0 of every cycle. An overflow in one cycle does not carry into the next result.
- R8: A synchronous reset forces `mod_out`, `result_bcd`, `overflow`, `xfer_strobe` and `conv_done` to 0. They stay at 0, except `mod_out`, until the first transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_in | input | 1 | Comparator decision from the analog loop |
| mod_out | output | 1 | Registered modulator bit that drives the reference switch |
| result_bcd | output | 16 | Four-digit BCD result of the last conversion |
| overflow | output | 1 | Last conversion exceeded full scale |
| xfer_strobe | output | 1 | One-clock pulse when a new result is loaded |
| conv_done | output | 1 | Completion flag, high for HOLD_CLKS clocks per cycle |

## Verification
The comparator stream is driven with several patterns. A constant-low stream gives a zero result and shows that the counter clears. A constant-high stream forces the exact full-scale count and the all-E code. High streams with one or two dropped samples land on the largest legal reading and test the prescaler floor at the boundary. Alternating and one-in-four streams, plus random densities from a seeded generator, show that the count follows the duty cycle through every decade carry. The bench derives its expected result from the `mod_out` bits it sees inside the window, so it also checks that the feedback bit is registered.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  parameter int DIGIT_COUNT = 4;
  localparam int WORD_W = 4 * DIGIT_COUNT;

  typedef logic [3:0]        bcd_digit_t;
  typedef logic [WORD_W-1:0] bcd_word_t;

  function automatic bcd_word_t to_bcd(input int unsigned value);
    bcd_word_t   w;
    int unsigned v;
    v = value;
    w = '0;
    for (int i = 0; i < DIGIT_COUNT; i++) begin
      w[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return w;
  endfunction

  function automatic bcd_word_t all_e();
    bcd_word_t w;
    for (int i = 0; i < DIGIT_COUNT; i++) w[4*i +: 4] = 4'hE;
    return w;
  endfunction
endpackage

// File: rtl/pdm_cycle_seq.sv
module pdm_cycle_seq #(
  parameter int WINDOW_CLKS = 64000,
  parameter int TAIL_CLKS   = 512,
  parameter int HOLD_CLKS   = 64
) (
  input  logic clk,
  input  logic rst,
  output logic win_first,
  output logic in_window,
  output logic xfer_now,
  output logic strobe_q,
  output logic done_q
);
  localparam int CYCLE = WINDOW_CLKS + TAIL_CLKS;
  localparam int CW    = $clog2(CYCLE);

  logic [CW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst)                         pos_q <= '0;
    else if (pos_q == CW'(CYCLE-1))  pos_q <= '0;
    else                             pos_q <= pos_q + 1'b1;
  end

  assign win_first = (pos_q == '0);
  assign in_window = (pos_q < CW'(WINDOW_CLKS));
  assign xfer_now  = (pos_q == CW'(WINDOW_CLKS));

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      strobe_q <= xfer_now;
      done_q   <= (pos_q >= CW'(WINDOW_CLKS)) &&
                  ({1'b0, pos_q} < (CW+1)'(WINDOW_CLKS + HOLD_CLKS));
    end
  end

  // R4: strobe never lasts two clocks
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
    strobe_q |=> !strobe_q);
  // R5: completion flag rises only together with the strobe
  p_done_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> strobe_q);
  // R5: strobe always inside the completion interval
  p_strobe_in_done_r5: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> done_q);
endmodule

// File: rtl/pdm_prescaler.sv
module pdm_prescaler #(
  parameter int PRESCALE = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic gate,
  output logic tick
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] frac_q;
  logic [PW-1:0] base;

  assign base = clr ? '0 : frac_q;
  assign tick = gate && (base == PW'(PRESCALE-1));

  always_ff @(posedge clk) begin
    if (rst)       frac_q <= '0;
    else if (tick) frac_q <= '0;
    else if (gate) frac_q <= base + 1'b1;
    else           frac_q <= base;
  end

  // R2: a count tick only comes from a gated clock
  p_tick_gated_r2: assert property (@(posedge clk) disable iff (rst)
    tick |-> gate);
endmodule

// File: rtl/pdm_decade.sv
module pdm_decade (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       inc,
  output logic [3:0] digit,
  output logic       carry
);
  logic [3:0] base;

  assign base  = clr ? 4'd0 : digit;
  assign carry = inc && (base == 4'd9);

  always_ff @(posedge clk) begin
    if (rst)        digit <= 4'd0;
    else if (carry) digit <= 4'd0;
    else if (inc)   digit <= base + 4'd1;
    else            digit <= base;
  end

  // R2: each stage stays a legal decimal digit
  p_digit_legal_r2: assert property (@(posedge clk) disable iff (rst)
    digit <= 4'd9);
endmodule

// File: rtl/pdm_bcd_accum.sv
module pdm_bcd_accum
  import pdm_pkg::*;
#(
  parameter int FULL_SCALE = 2000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      tick,
  output bcd_word_t count_bcd,
  output logic      ovf_q
);
  localparam bcd_word_t MAX_BCD = to_bcd(FULL_SCALE - 1);

  logic                 base_ovf;
  logic                 at_max;
  logic [DIGIT_COUNT:0] ripple;

  assign base_ovf  = clr ? 1'b0 : ovf_q;
  assign at_max    = !clr && (count_bcd == MAX_BCD);
  assign ripple[0] = tick && !base_ovf && !at_max;

  for (genvar g = 0; g < DIGIT_COUNT; g++) begin : g_stage
    pdm_decade u_dec (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr),
      .inc   (ripple[g]),
      .digit (count_bcd[4*g +: 4]),
      .carry (ripple[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_q <= 1'b0;
    else     ovf_q <= base_ovf || (tick && at_max);
  end

  // R3: overflow stays set until the next window clear
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr) |=> ovf_q);
  // R3: the count never runs past full scale
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    count_bcd <= MAX_BCD);
endmodule

// File: rtl/pdm_bcd_converter.sv
module pdm_bcd_converter
  import pdm_pkg::*;
#(
  parameter int FULL_SCALE = 2000,
  parameter int PRESCALE   = 32,
  parameter int TAIL_CLKS  = 512,
  parameter int HOLD_CLKS  = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        comp_in,
  output logic        mod_out,
  output logic [15:0] result_bcd,
  output logic        overflow,
  output logic        xfer_strobe,
  output logic        conv_done
);
  localparam int WINDOW_CLKS = FULL_SCALE * PRESCALE;

  logic      win_first, in_window, xfer_now;
  logic      tick, ovf_q;
  bcd_word_t count_bcd;
  bcd_word_t result_q;
  logic      overflow_q;

  always_ff @(posedge clk) begin
    if (rst) mod_out <= 1'b0;
    else     mod_out <= comp_in;
  end

  pdm_cycle_seq #(
    .WINDOW_CLKS (WINDOW_CLKS),
    .TAIL_CLKS   (TAIL_CLKS),
    .HOLD_CLKS   (HOLD_CLKS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .win_first (win_first),
    .in_window (in_window),
    .xfer_now  (xfer_now),
    .strobe_q  (xfer_strobe),
    .done_q    (conv_done)
  );

  pdm_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (win_first),
    .gate (mod_out && in_window),
    .tick (tick)
  );

  pdm_bcd_accum #(.FULL_SCALE(FULL_SCALE)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .clr       (win_first),
    .tick      (tick),
    .count_bcd (count_bcd),
    .ovf_q     (ovf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q   <= '0;
      overflow_q <= 1'b0;
    end else if (xfer_now) begin
      result_q   <= ovf_q ? all_e() : count_bcd;
      overflow_q <= ovf_q;
    end
  end

  assign result_bcd = 16'(result_q);
  assign overflow   = overflow_q;

  // R1: modulator bit is the previous comparator decision
  p_mod_follow_r1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> mod_out == $past(comp_in));
  // R3: overflow always shows the all-E code
  p_ovf_code_r3: assert property (@(posedge clk) disable iff (rst)
    overflow |-> result_q == all_e());
  // R6: result moves only with a strobe
  p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !xfer_strobe |-> $stable(result_bcd) || $past(rst));
endmodule

// File: tb/test_pdm_bcd_converter.sv
module test_pdm_bcd_converter;
  localparam int FS     = 2000;
  localparam int PRE    = 2;
  localparam int TAIL   = 32;
  localparam int HOLD   = 8;
  localparam int WIN    = FS * PRE;
  localparam int CYCLE  = WIN + TAIL;
  localparam int NCONV  = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        comp_in = 1'b0;
  logic        mod_out;
  logic [15:0] result_bcd;
  logic        overflow;
  logic        xfer_strobe;
  logic        conv_done;

  int n_vec  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pdm_bcd_converter #(
    .FULL_SCALE (FS),
    .PRESCALE   (PRE),
    .TAIL_CLKS  (TAIL),
    .HOLD_CLKS  (HOLD)
  ) i_pdm_bcd_converter (
    .clk         (clk),
    .rst         (rst),
    .comp_in     (comp_in),
    .mod_out     (mod_out),
    .result_bcd  (result_bcd),
    .overflow    (overflow),
    .xfer_strobe (xfer_strobe),
    .conv_done   (conv_done)
  );

  function automatic logic [15:0] exp_bcd(input int v);
    logic [15:0] w;
    int r;
    r = v;
    for (int i = 0; i < 4; i++) begin
      w[4*i +: 4] = 4'(r % 10);
      r = r / 10;
    end
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    int          p;
    int          conv;
    int          ones;
    int          thr;
    int          cnt;
    logic [15:0] hold_res;
    logic        hold_ovf;
    logic        drive;

    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R8: reset state
    chk("R8 mod_out",   32'(mod_out), 0);
    chk("R8 result",    32'(result_bcd), 0);
    chk("R8 overflow",  32'(overflow), 0);
    chk("R8 strobe",    32'(xfer_strobe), 0);
    chk("R8 done",      32'(conv_done), 0);
    rst = 1'b0;

    p = 0; conv = 0; ones = 0; thr = 50;
    hold_res = '0; hold_ovf = 1'b0;
    while (conv < NCONV) begin
      if (p == 0) begin
        ones = 0;
        thr  = int'($urandom % 101);
      end
      if (p < WIN) ones += int'(mod_out);
      case (conv)
        0, 2, 3: drive = 1'b1;
        1:       drive = 1'b0;
        4:       drive = !(p == 700 || p == 2500);
        5:       drive = p[0];
        6:       drive = (p % 4 == 0);
        default: drive = (int'($urandom % 100) < thr);
      endcase
      comp_in = drive;
      @(posedge clk);
      @(negedge clk);
      // R1: registered comparator bit
      chk("R1 mod_out", 32'(mod_out), 32'(drive));
      if (p == WIN) begin
        cnt = ones / PRE;
        hold_ovf = (cnt > FS - 1);
        hold_res = hold_ovf ? 16'hEEEE : exp_bcd(cnt);
        // R2 / R3 / R7: transferred value computed from observed duty
        chk(hold_ovf ? "R3 result" : "R2 R7 result", 32'(result_bcd), 32'(hold_res));
        chk("R3 overflow", 32'(overflow), 32'(hold_ovf));
        chk("R4 strobe", 32'(xfer_strobe), 1);
      end else begin
        chk("R4 strobe", 32'(xfer_strobe), 0);
        chk("R6 result held", 32'(result_bcd), 32'(hold_res));
        chk("R6 overflow held", 32'(overflow), 32'(hold_ovf));
      end
      // R5: completion flag window
      chk("R5 done", 32'(conv_done), 32'((p >= WIN) && (p < WIN + HOLD)));
      if (p == CYCLE - 1) begin
        p = 0;
        conv++;
      end else begin
        p++;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule